// File: doc/BRIEF.md
# DMA Channel Register File

This block is the host-facing register file of a four-channel DMA controller. A host reaches every register through a 4-bit offset and an 8-bit data port, one byte per access. Each channel has a 16-bit address register and a 16-bit count register. The block keeps a programmed (base) copy and a running (current) copy of each. A single byte-pointer flip-flop, shared by all channels, picks which half of a 16-bit register the next access touches.

Beside the channel registers, the block holds a mode byte for each channel, a 4-bit channel mask and a status byte. It decodes the single-bit mask, load-all mask, clear-mask, pointer-clear and master-reset commands. The current address, current count, mode bytes and mask leave the block as flat vectors for a transfer engine.

Offset map:
- Offsets 0, 2, 4 and 6 are the address ports of channels 0 to 3.
- Offsets 1, 3, 5 and 7 are the count ports of channels 0 to 3.
- Offset 8 is status on a read; a write there is accepted and ignored.
- Offset 9 is request and is ignored.
- Offset 10 is the single mask bit command.
- Offset 11 is the mode write.
- Offset 12 clears the byte pointer.
- Offset 13 is master reset.
- Offset 14 clears the mask.
- Offset 15 loads the whole mask.

Top module: `dma_chan_regs`

## Requirements
- R1: Any read or write at offsets 0 to 7 inverts the shared byte pointer. The access uses bits 7:0 when the pointer is clear and bits 15:8 when it is set. One channel's access moves the pointer for all channels.
- R2: A low-byte address write changes only the base address. A high-byte address write sets the base high byte and then copies the full 16-bit base address into the current address.
- R3: Each byte written to a count port is stored as the byte plus one, modulo 256. A high-byte count write copies the full base count into the current count.
- R4: Reads at offsets 0 to 7 return a byte of the current address or current count, never of the base value.
- R5: A write to offset 10 uses data bits 1:0 as the channel. Data bit 2 set masks that channel; bit 2 clear unmasks it. The other mask bits are unchanged.
- R6: A write to offset 15 loads the mask from data bits 3:0. A write to offset 14 clears all four mask bits.
- R7: A write to offset 13 clears the byte pointer and sets the mask to 4'hF. A write to offset 12 clears only the byte pointer.
- R8: A write to offset 11 stores the whole data byte as the mode of the channel named by data bits 1:0. Channel c's mode appears on modeOut[8c+7:8c].
- R9: After reset, the mask is 4'hF, the pointer is clear, all address, count and mode registers are zero, and a read of offset 8 returns 8'h00.
- R10: Read data is 8'h00 when rdEn is low or the offset is 9 to 15. Accesses at offsets 8 to 15 other than 12 and 13 leave the byte pointer unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register offset |
| wrEn | input | 1 | Write strobe, one access per cycle |
| rdEn | input | 1 | Read strobe, one access per cycle |
| wrData | input | 8 | Write data byte |
| rdData | output | 8 | Read data byte, valid in the cycle of rdEn |
| curAddrOut | output | 64 | Current address of each channel, 16 bits per channel |
| curCountOut | output | 64 | Current count of each channel, 16 bits per channel |
| modeOut | output | 32 | Mode byte of each channel |
| maskOut | output | 4 | Channel mask, bit c for channel c |

## Verification
The bench builds the block with its defaults: four channels and 8-bit bytes, so 16-bit registers and 2-bit channel fields. This lets every offset be driven by name. It also makes the count wrap at 8'hFF plus one reachable, and puts every mask command within a few writes. With this setting, one channel's access leaving the shared pointer on the high byte for the next channel can be shown in one short sequence.

// File: rtl/dma_regs_pkg.sv
package dma_regs_pkg;
  localparam int NUM_CHAN = 4;
  localparam int CHAN_W   = $clog2(NUM_CHAN);
  localparam int PORT_W   = 4;

  localparam logic [PORT_W-1:0] OFS_STATUS = 4'd8;
  localparam logic [PORT_W-1:0] OFS_MASK1  = 4'd10;
  localparam logic [PORT_W-1:0] OFS_MODE   = 4'd11;
  localparam logic [PORT_W-1:0] OFS_CLRPTR = 4'd12;
  localparam logic [PORT_W-1:0] OFS_MRST   = 4'd13;
  localparam logic [PORT_W-1:0] OFS_MCLR   = 4'd14;
  localparam logic [PORT_W-1:0] OFS_MALL   = 4'd15;

  typedef struct packed {
    logic              chanWr;
    logic              chanRd;
    logic              hiByte;
    logic              isCount;
    logic [CHAN_W-1:0] chan;
    logic              modeWr;
    logic              maskBitWr;
    logic              maskLoadAll;
    logic              maskClear;
    logic              maskSetAll;
    logic              statusRd;
  } strobe_t;
endpackage

// File: rtl/dma_reg_ctrl.sv
module dma_reg_ctrl
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = NUM_CHAN
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [PORT_W-1:0] addr,
  input  logic              wrEn,
  input  logic              rdEn,
  output strobe_t           st
);
  localparam logic [PORT_W-1:0] CHAN_PORTS = PORT_W'(2 * NUM_CH);

  logic ptrHi;
  logic chanPort;
  logic chanAccess;
  logic ptrClear;

  assign chanPort   = (addr < CHAN_PORTS);
  assign chanAccess = chanPort && (rdEn || wrEn);
  assign ptrClear   = wrEn && ((addr == OFS_CLRPTR) || (addr == OFS_MRST));

  always_ff @(posedge clk) begin
    if (rst)             ptrHi <= 1'b0;
    else if (ptrClear)   ptrHi <= 1'b0;
    else if (chanAccess) ptrHi <= ~ptrHi;
  end

  always_comb begin
    st             = '0;
    st.hiByte      = ptrHi;
    st.isCount     = addr[0];
    st.chan        = addr[CHAN_W:1];
    st.chanWr      = wrEn && chanPort;
    st.chanRd      = rdEn && !wrEn && chanPort;
    st.statusRd    = rdEn && !wrEn && (addr == OFS_STATUS);
    st.modeWr      = wrEn && (addr == OFS_MODE);
    st.maskBitWr   = wrEn && (addr == OFS_MASK1);
    st.maskLoadAll = wrEn && (addr == OFS_MALL);
    st.maskClear   = wrEn && (addr == OFS_MCLR);
    st.maskSetAll  = wrEn && (addr == OFS_MRST);
  end

  // R1: a channel access flips the shared pointer
  a_r1_ptr_flips: assert property (@(posedge clk) disable iff (rst)
    (chanAccess && !ptrClear) |=> (ptrHi != $past(ptrHi)));

  // R7: pointer-clear and master reset leave the pointer on the low byte
  a_r7_ptr_cleared: assert property (@(posedge clk) disable iff (rst)
    ptrClear |=> !ptrHi);

  // R10: non-channel accesses do not move the pointer
  a_r10_ptr_held: assert property (@(posedge clk) disable iff (rst)
    (!chanPort && !ptrClear) |=> $stable(ptrHi));
endmodule

// File: rtl/dma_reg_datapath.sv
module dma_reg_datapath
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = NUM_CHAN,
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  strobe_t                    st,
  input  logic [BYTE_W-1:0]          wrData,
  output logic [BYTE_W-1:0]          rdData,
  output logic [NUM_CH*2*BYTE_W-1:0] curAddrOut,
  output logic [NUM_CH*2*BYTE_W-1:0] curCountOut,
  output logic [NUM_CH*BYTE_W-1:0]   modeOut,
  output logic [NUM_CH-1:0]          maskOut
);
  localparam int REG_W = 2 * BYTE_W;

  logic [REG_W-1:0]  baseAddr  [NUM_CH];
  logic [REG_W-1:0]  curAddr   [NUM_CH];
  logic [REG_W-1:0]  baseCount [NUM_CH];
  logic [REG_W-1:0]  curCount  [NUM_CH];
  logic [BYTE_W-1:0] modeReg   [NUM_CH];
  logic [NUM_CH-1:0] maskReg;
  logic [BYTE_W-1:0] statusReg;
  logic [BYTE_W-1:0] incByte;
  logic [REG_W-1:0]  rdWord;

  assign incByte = wrData + {{(BYTE_W-1){1'b0}}, 1'b1};

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chan
    logic hitAddr;
    logic hitCount;
    logic hitMode;
    assign hitAddr  = st.chanWr && !st.isCount && (st.chan == CHAN_W'(c));
    assign hitCount = st.chanWr &&  st.isCount && (st.chan == CHAN_W'(c));
    assign hitMode  = st.modeWr && (wrData[CHAN_W-1:0] == CHAN_W'(c));

    always_ff @(posedge clk) begin
      if (rst) begin
        baseAddr[c] <= '0;
        curAddr[c]  <= '0;
      end else if (hitAddr) begin
        if (!st.hiByte) begin
          baseAddr[c][BYTE_W-1:0] <= wrData;
        end else begin
          baseAddr[c][REG_W-1:BYTE_W] <= wrData;
          curAddr[c] <= {wrData, baseAddr[c][BYTE_W-1:0]};
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        baseCount[c] <= '0;
        curCount[c]  <= '0;
      end else if (hitCount) begin
        if (!st.hiByte) begin
          baseCount[c][BYTE_W-1:0] <= incByte;
        end else begin
          baseCount[c][REG_W-1:BYTE_W] <= incByte;
          curCount[c] <= {incByte, baseCount[c][BYTE_W-1:0]};
        end
      end
    end

    always_ff @(posedge clk) begin
      if (rst)          modeReg[c] <= '0;
      else if (hitMode) modeReg[c] <= wrData;
    end

    assign curAddrOut[c*REG_W +: REG_W]   = curAddr[c];
    assign curCountOut[c*REG_W +: REG_W]  = curCount[c];
    assign modeOut[c*BYTE_W +: BYTE_W]    = modeReg[c];
  end

  always_ff @(posedge clk) begin
    if (rst)                 maskReg <= '1;
    else if (st.maskSetAll)  maskReg <= '1;
    else if (st.maskClear)   maskReg <= '0;
    else if (st.maskLoadAll) maskReg <= wrData[NUM_CH-1:0];
    else if (st.maskBitWr)   maskReg[wrData[CHAN_W-1:0]] <= wrData[CHAN_W];
  end

  always_ff @(posedge clk) begin
    if (rst) statusReg <= '0;
  end

  assign maskOut = maskReg;

  always_comb begin
    rdWord = st.isCount ? curCount[st.chan] : curAddr[st.chan];
    if (st.chanRd)        rdData = st.hiByte ? rdWord[REG_W-1:BYTE_W] : rdWord[BYTE_W-1:0];
    else if (st.statusRd) rdData = statusReg;
    else                  rdData = '0;
  end

  // R2: after a high address write the current address equals the base
  a_r2_cur_follows_base: assert property (@(posedge clk) disable iff (rst)
    (st.chanWr && st.hiByte && !st.isCount) |=>
      (curAddr[$past(st.chan)] == baseAddr[$past(st.chan)]));

  // R3: a low count byte lands as the written byte plus one
  a_r3_count_plus_one: assert property (@(posedge clk) disable iff (rst)
    (st.chanWr && !st.hiByte && st.isCount) |=>
      (baseCount[$past(st.chan)][BYTE_W-1:0] == BYTE_W'($past(wrData) + 1'b1)));

  // R6: clear-mask leaves every channel unmasked
  a_r6_mask_cleared: assert property (@(posedge clk) disable iff (rst)
    (st.maskClear && !st.maskSetAll) |=> (maskReg == '0));

  // R7: master reset masks every channel
  a_r7_mask_all_set: assert property (@(posedge clk) disable iff (rst)
    st.maskSetAll |=> (&maskReg));

  // R5: a single-bit mask command touches one bit only
  a_r5_one_bit_changes: assert property (@(posedge clk) disable iff (rst)
    (st.maskBitWr && !st.maskSetAll && !st.maskClear && !st.maskLoadAll) |=>
      ($countones(maskReg ^ $past(maskReg)) <= 1));
endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_regs_pkg::*;
#(
  parameter int NUM_CH = NUM_CHAN,
  parameter int BYTE_W = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [PORT_W-1:0]          addr,
  input  logic                       wrEn,
  input  logic                       rdEn,
  input  logic [BYTE_W-1:0]          wrData,
  output logic [BYTE_W-1:0]          rdData,
  output logic [NUM_CH*2*BYTE_W-1:0] curAddrOut,
  output logic [NUM_CH*2*BYTE_W-1:0] curCountOut,
  output logic [NUM_CH*BYTE_W-1:0]   modeOut,
  output logic [NUM_CH-1:0]          maskOut
);
  strobe_t st;

  dma_reg_ctrl #(.NUM_CH(NUM_CH)) i_ctrl (
    .clk  (clk),
    .rst  (rst),
    .addr (addr),
    .wrEn (wrEn),
    .rdEn (rdEn),
    .st   (st)
  );

  dma_reg_datapath #(.NUM_CH(NUM_CH), .BYTE_W(BYTE_W)) i_dp (
    .clk         (clk),
    .rst         (rst),
    .st          (st),
    .wrData      (wrData),
    .rdData      (rdData),
    .curAddrOut  (curAddrOut),
    .curCountOut (curCountOut),
    .modeOut     (modeOut),
    .maskOut     (maskOut)
  );
endmodule

// File: tb/test_dma_chan_regs.sv
`timescale 1ns/1ps
module test_dma_chan_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  addr = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic [7:0]  rdData;
  logic [63:0] curAddrOut;
  logic [63:0] curCountOut;
  logic [31:0] modeOut;
  logic [3:0]  maskOut;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  dma_chan_regs i_dma_chan_regs (
    .clk(clk), .rst(rst), .addr(addr), .wrEn(wrEn), .rdEn(rdEn),
    .wrData(wrData), .rdData(rdData), .curAddrOut(curAddrOut),
    .curCountOut(curCountOut), .modeOut(modeOut), .maskOut(maskOut)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ofs, input int d);
    @(negedge clk);
    addr = 4'(ofs); wrData = 8'(d); wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input int ofs, output int v);
    @(negedge clk);
    addr = 4'(ofs); rdEn = 1'b1;
    #1 v = int'(rdData);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  function automatic int curA(input int c); return int'(curAddrOut[c*16 +: 16]); endfunction
  function automatic int curC(input int c); return int'(curCountOut[c*16 +: 16]); endfunction
  function automatic int modeOf(input int c); return int'(modeOut[c*8 +: 8]); endfunction

  task automatic tReset;
    int v;
    chk("R9 mask", int'(maskOut), 'hF);
    chk("R10 idle rdData", int'(rdData), 0);
    for (int c = 0; c < 4; c++) begin
      chk("R9 curAddr", curA(c), 0);
      chk("R9 mode", modeOf(c), 0);
    end
    rd(8, v); chk("R9 status", v, 0);
  endtask

  task automatic tAddr;
    int v;
    wr(4, 'h34);
    chk("R2 low write leaves current", curA(2), 0);
    wr(4, 'h12);
    chk("R2 high write loads current", curA(2), 'h1234);
    rd(4, v); chk("R4 addr low read", v, 'h34);
    rd(4, v); chk("R1 R4 addr high read", v, 'h12);
  endtask

  task automatic tCount;
    int v;
    wr(3, 'h0F); wr(3, 'h02);
    chk("R3 count plus one", curC(1), 'h0310);
    wr(7, 'hFF); wr(7, 'hFF);
    chk("R3 count wrap", curC(3), 'h0000);
    rd(3, v); chk("R4 count low read", v, 'h10);
    rd(3, v); chk("R4 count high read", v, 'h03);
  endtask

  task automatic tSharedPtr;
    wr(0, 'hAA);
    wr(3, 'h05);
    chk("R1 shared ptr hits high byte", curC(1), 'h0610);
    chk("R1 other channel current", curA(0), 0);
  endtask

  task automatic tStale;
    int v;
    wr(0, 'h55);
    wr(12, 0);
    rd(0, v); chk("R4 current not base low", v, 0);
    rd(0, v); chk("R4 current not base high", v, 0);
  endtask

  task automatic tClrPtr;
    wr(4, 'h77);
    wr(12, 0);
    wr(4, 'h99); wr(4, 'h88);
    chk("R7 ptr clear", curA(2), 'h8899);
  endtask

  task automatic tMask;
    int v;
    wr(14, 0);       chk("R6 clear mask", int'(maskOut), 0);
    wr(10, 'b110);   chk("R5 set bit", int'(maskOut), 'b0100);
    wr(10, 'b001);   chk("R5 clear bit", int'(maskOut), 'b0100);
    wr(10, 'b010);   chk("R5 clear ch2", int'(maskOut), 0);
    wr(15, 'hA5);    chk("R6 load all", int'(maskOut), 'h5);
    wr(0, 'h01);
    wr(13, 0);       chk("R7 master mask", int'(maskOut), 'hF);
    rd(4, v);        chk("R7 master clears ptr", v, 'h99);
    rd(4, v);
  endtask

  task automatic tMode;
    wr(11, 'h4A);
    chk("R8 mode ch2", modeOf(2), 'h4A);
    wr(11, 'h57);
    chk("R8 mode ch3", modeOf(3), 'h57);
    chk("R8 ch2 kept", modeOf(2), 'h4A);
    chk("R8 ch0 kept", modeOf(0), 0);
  endtask

  task automatic tIgnored;
    int v;
    for (int o = 9; o < 16; o++) begin
      rd(o, v); chk("R10 read zero", v, 0);
    end
    wr(8, 'hFF); wr(9, 'hFF);
    chk("R10 ignored mask", int'(maskOut), 'hF);
    chk("R10 ignored mode", modeOf(3), 'h57);
    rd(4, v); chk("R10 ptr unchanged", v, 'h99);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    tReset;
    tAddr;
    tCount;
    tSharedPtr;
    tStale;
    tClrPtr;
    tMask;
    tMode;
    tIgnored;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule